// File: doc/BRIEF.md
# Frame-Synchronous Byte Scrambler

This block whitens a byte-wide synchronous transport stream whose frame is 9 rows of 270 byte-columns (2,430 bytes, sent row by row, left to right). Each accepted byte is XORed with eight keystream bits from a 7-stage linear feedback generator built on the polynomial x^7 + x^6 + 1. The first keystream bit of a byte lands on its most significant bit, which is the bit that goes on the line first. The generator restarts from all ones at a fixed point in every frame. The first nine bytes of row 1 carry framing and trace overhead, and they are never whitened.

A start-of-frame marker travels with the first byte of a frame. After that, the block tracks its own row and column, so later frames stay aligned even with no new marker. Because the operation is a plain XOR with a keystream that depends only on frame position, one instance can sit on the transmit side as the scrambler and another on the receive side as the descrambler.

Internally, a three-state controller sets the treatment of each byte. HUNT is the state out of reset. In HUNT no frame position is known, and bytes pass through untouched. The transition HUNT→OVERHEAD ("lock") fires on any valid byte that carries the marker. OVERHEAD covers the nine leading bytes of row 1, which pass through unchanged. The transition OVERHEAD→SCRAMBLE ("seed") fires as the ninth overhead byte is accepted, and it loads the generator with all ones. SCRAMBLE whitens every other byte of the frame. SCRAMBLE→OVERHEAD ("wrap") fires on the last byte of row 9. SCRAMBLE→OVERHEAD ("resync") fires on any byte that carries the marker. OVERHEAD→OVERHEAD on a marker restarts the count.

Top module: `frame_scrambler`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `out_data` is 0x00.
- R2: Until the first byte with `in_sof`=1 is accepted, every valid byte appears unchanged on `out_data`.
- R3: The byte that carries `in_sof` and the eight valid bytes after it (row 1, columns 1 to 9) appear unchanged on `out_data`.
- R4: The tenth byte of a frame (row 1, column 10) is XORed with 0xFE, the first keystream byte from the all-ones seed.
- R5: Each later byte of the frame, including columns 1 to 9 of rows 2 to 9, is XORed with the next eight keystream bits. The keystream comes from state s[6:0]: output bit s[6], then s becomes {s[5:0], s[6]^s[5]}. The first output bit goes to bit 7.
- R6: After 2,430 valid bytes with no new marker, the count wraps. The next frame again passes nine bytes unchanged and XORs its tenth byte with 0xFE.
- R7: A cycle with `in_valid`=0 gives `out_valid`=0 one cycle later. Such a cycle advances neither the byte position nor the keystream, so idle gaps do not change any later output byte.
- R8: A byte that carries `in_sof` in the middle of a frame restarts the position at row 1, column 1.
- R9: Feeding a scrambled frame through the block again, aligned with the same marker, returns the original bytes.
- R10: `out_valid` and `out_data` are registered one cycle after the input byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Input byte, bit 7 first on the line |
| in_valid | input | 1 | Input byte strobe |
| in_sof | input | 1 | Marks the byte at row 1, column 1; only meaningful with `in_valid` |
| out_data | output | 8 | Scrambled or descrambled byte |
| out_valid | output | 1 | Output byte strobe, one cycle after `in_valid` |

## Verification
A wrong position count shows on the next scrambled byte after the slip. The overhead window either moves or whitens bytes it should pass through. A wrong keystream state corrupts every output byte until the next seed point, so a single long frame exposes it within one byte. A faulty state transition shows in two places: at the wrap, when the tenth byte of the next frame is not XORed with 0xFE, and on a mid-frame marker, which must return nine clean bytes at once. Idle cycles inserted between bytes check that a stall leaves the position and keystream untouched, because a stall that advanced either one would shift every later output byte.

// File: rtl/fscr_pkg.sv
package fscr_pkg;
    localparam int FRAME_ROWS    = 9;
    localparam int FRAME_COLS    = 270;
    localparam int CLEAR_BYTES   = 9;
    localparam int GEN_STAGES    = 7;
    localparam int GEN_TAP_HI    = 6;
    localparam int GEN_TAP_LO    = 5;
    localparam int DATA_W        = 8;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_OVERHEAD,
        ST_SCRAMBLE
    } scr_state_e;
endpackage

// File: rtl/fscr_position.sv
module fscr_position
    import fscr_pkg::*;
#(
    parameter int ROWS  = FRAME_ROWS,
    parameter int COLS  = FRAME_COLS,
    parameter int CLEAR = CLEAR_BYTES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_ok,
    input  logic sof,
    output logic scramble_now,
    output logic seed_load
);
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
    localparam logic [ROW_W-1:0] LAST_ROW  = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] LAST_COL  = COL_W'(COLS - 1);
    localparam logic [COL_W-1:0] CLEAR_END = COL_W'(CLEAR - 1);

    scr_state_e state_q, state_d;
    logic [ROW_W-1:0] row_q, row_d, cur_row;
    logic [COL_W-1:0] col_q, col_d, cur_col;
    logic             end_of_frame;
    logic             end_of_clear;

    // Position of the byte on the bus now; a marker forces row 1, column 1
    always_comb begin
        cur_row = sof ? '0 : row_q;
        cur_col = sof ? '0 : col_q;
    end

    assign end_of_frame = (cur_row == LAST_ROW) && (cur_col == LAST_COL);
    assign end_of_clear = (cur_row == '0) && (cur_col == CLEAR_END);

    // Position of the following byte
    always_comb begin
        row_d = row_q;
        col_d = col_q;
        if (byte_ok && (sof || state_q != ST_HUNT)) begin
            if (cur_col == LAST_COL) begin
                col_d = '0;
                row_d = (cur_row == LAST_ROW) ? '0 : cur_row + 1'b1;
            end else begin
                col_d = cur_col + 1'b1;
                row_d = cur_row;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (byte_ok) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (sof) state_d = end_of_clear ? ST_SCRAMBLE : ST_OVERHEAD;
                end
                ST_OVERHEAD: begin
                    if (end_of_clear) state_d = ST_SCRAMBLE;
                    else              state_d = ST_OVERHEAD;
                end
                ST_SCRAMBLE: begin
                    if (sof)               state_d = end_of_clear ? ST_SCRAMBLE : ST_OVERHEAD;
                    else if (end_of_frame) state_d = ST_OVERHEAD;
                    else                   state_d = ST_SCRAMBLE;
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // State and position registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            row_q   <= '0;
            col_q   <= '0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
            col_q   <= col_d;
        end
    end

    // Outputs per state
    always_comb begin
        scramble_now = 1'b0;
        seed_load    = 1'b0;
        unique case (state_q)
            ST_HUNT:     seed_load    = byte_ok && sof && end_of_clear;
            ST_OVERHEAD: seed_load    = byte_ok && end_of_clear;
            ST_SCRAMBLE: begin
                scramble_now = byte_ok && !sof;
                seed_load    = byte_ok && sof && end_of_clear;
            end
            default: ;
        endcase
    end

    // R7: an idle cycle leaves the position and the state untouched
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_ok |=> $stable(row_q) && $stable(col_q) && $stable(state_q));

    // R6: the position counters stay inside the frame
    assert_pos_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (row_q <= LAST_ROW) && (col_q <= LAST_COL));

    // R8: a marker byte always restarts the count just after row 1, column 1
    assert_sof_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ok && sof) |=> (row_q == '0) && (col_q == COL_W'(1 % COLS)));

    // R3: no whitening is done on a marker byte
    assert_sof_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> !scramble_now);
endmodule

// File: rtl/fscr_keystream.sv
module fscr_keystream
    import fscr_pkg::*;
#(
    parameter int STAGES = GEN_STAGES,
    parameter int TAP_HI = GEN_TAP_HI,
    parameter int TAP_LO = GEN_TAP_LO,
    parameter int BYTE_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    output logic [BYTE_W-1:0] ks_byte
);
    localparam logic [STAGES-1:0] SEED = '1;

    logic [STAGES-1:0] gen_q;
    logic [STAGES-1:0] step [0:BYTE_W];

    assign step[0] = gen_q;

    // One byte's worth of generator steps unrolled; first bit goes to the MSB
    for (genvar i = 0; i < BYTE_W; i++) begin : g_step
        assign ks_byte[BYTE_W-1-i] = step[i][STAGES-1];
        assign step[i+1] = {step[i][STAGES-2:0], step[i][TAP_HI] ^ step[i][TAP_LO]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= SEED;
        end else if (load) begin
            gen_q <= SEED;
        end else if (advance) begin
            gen_q <= step[BYTE_W];
        end
    end

    // R5: the generator never reaches the all-zero lock-up state
    assert_no_lockup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q != '0);

    // R7: without a byte to whiten the generator holds
    assert_gen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> $stable(gen_q));

    // R4: the generator holds the seed after a load
    assert_seed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (gen_q == SEED));
endmodule

// File: rtl/frame_scrambler.sv
module frame_scrambler
    import fscr_pkg::*;
#(
    parameter int ROWS   = FRAME_ROWS,
    parameter int COLS   = FRAME_COLS,
    parameter int CLEAR  = CLEAR_BYTES,
    parameter int STAGES = GEN_STAGES,
    parameter int TAP_HI = GEN_TAP_HI,
    parameter int TAP_LO = GEN_TAP_LO,
    parameter int BYTE_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_sof,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid
);
    logic              scramble_now;
    logic              seed_load;
    logic [BYTE_W-1:0] ks_byte;
    logic [BYTE_W-1:0] mask;

    fscr_position #(
        .ROWS  (ROWS),
        .COLS  (COLS),
        .CLEAR (CLEAR)
    ) u_pos (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_ok      (in_valid),
        .sof          (in_sof),
        .scramble_now (scramble_now),
        .seed_load    (seed_load)
    );

    fscr_keystream #(
        .STAGES (STAGES),
        .TAP_HI (TAP_HI),
        .TAP_LO (TAP_LO),
        .BYTE_W (BYTE_W)
    ) u_ks (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (seed_load),
        .advance (scramble_now),
        .ks_byte (ks_byte)
    );

    assign mask = scramble_now ? ks_byte : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_data  <= in_valid ? (in_data ^ mask) : '0;
        end
    end

    // R10: the output strobe follows the input strobe by one cycle
    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7: no output byte for an idle input cycle
    assert_idle_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: a marker byte leaves the block unchanged
    assert_sof_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> (out_data == $past(in_data)));
endmodule

// File: tb/frame_scrambler_test.sv
module frame_scrambler_test;
    localparam int NBYTES = 2430;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic [7:0] out_data;
    logic       out_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    bit         m_locked = 1'b0;
    int         m_idx = 0;
    logic [6:0] m_gen = 7'h7F;
    logic [7:0] pat = 8'h00;
    logic [7:0] saved [0:NBYTES-1];

    always #4 clk = ~clk;

    frame_scrambler uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // Model of one byte: keystream from x^7+x^6+1, MSB first, seed all ones
    task automatic model_byte(input logic [7:0] din, input bit sof,
                              output logic [7:0] exp, output int region);
        logic [7:0] ks;
        if (sof) begin
            m_locked = 1'b1;
            m_idx = 0;
        end
        if (!m_locked) begin
            exp = din;
            region = 2;
            return;
        end
        if (m_idx < 9) begin
            exp = din;
            region = 3;
            if (m_idx == 8) m_gen = 7'h7F;
        end else begin
            ks = 8'h00;
            for (int b = 7; b >= 0; b--) begin
                ks[b] = m_gen[6];
                m_gen = {m_gen[5:0], m_gen[6] ^ m_gen[5]};
            end
            exp = din ^ ks;
            region = (m_idx == 9) ? 4 : 5;
        end
        m_idx = (m_idx == NBYTES - 1) ? 0 : m_idx + 1;
    endtask

    // Drive one byte at a falling edge, check it at the next falling edge
    task automatic send(input logic [7:0] d, input bit sof, input string tag,
                        output logic [7:0] got);
        logic [7:0] exp;
        int region;
        string req;
        model_byte(d, sof, exp, region);
        in_data = d;
        in_sof = sof;
        in_valid = 1'b1;
        @(negedge clk);
        got = out_data;
        chk("R10 out_valid", {7'b0, out_valid}, 8'h01);
        case (region)
            2: req = "R2 hunt pass";
            3: req = "R3 clear bytes";
            4: req = "R4 first keystream byte";
            default: req = "R5 keystream";
        endcase
        if (tag != "") req = {tag, " ", req};
        chk(req, out_data, exp);
        if (region == 4) chk({req, " xor FE"}, out_data, d ^ 8'hFE);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b0;
            in_sof = 1'b0;
            in_data = 8'hA5;
            @(negedge clk);
            chk("R7 idle out_valid", {7'b0, out_valid}, 8'h00);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", {7'b0, out_valid}, 8'h00);
        chk("R1 reset out_data", out_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset out_valid", {7'b0, out_valid}, 8'h00);
        chk("R1 after reset out_data", out_data, 8'h00);
    endtask

    task automatic t_hunt;
        logic [7:0] g;
        for (int k = 0; k < 20; k++) begin
            send(8'h3C + 8'(k * 11), 1'b0, "R2", g);
        end
    endtask

    // Two frames from one marker, the second found by wrap (R6), with idle gaps (R7)
    task automatic t_frames_with_gaps;
        logic [7:0] g;
        for (int f = 0; f < 2; f++) begin
            for (int k = 0; k < NBYTES; k++) begin
                pat = pat * 8'd5 + 8'd17;
                send(pat, (f == 0 && k == 0), (f == 1) ? "R6" : "", g);
                if (k % 97 == 13) idle(2);
            end
        end
    endtask

    // Marker in mid-frame restarts the count (R8)
    task automatic t_mid_sof;
        logic [7:0] g;
        for (int k = 0; k < 500; k++) begin
            pat = pat + 8'd29;
            send(pat, 1'b0, "", g);
        end
        for (int k = 0; k < 30; k++) begin
            pat = pat ^ 8'h5A;
            send(pat, (k == 0), "R8", g);
        end
    endtask

    // Scramble a frame, then feed the result back aligned: originals return (R9)
    task automatic t_involution;
        logic [7:0] g;
        logic [7:0] orig [0:NBYTES-1];
        for (int k = 0; k < NBYTES; k++) begin
            orig[k] = 8'(k * 13 + 7);
            send(orig[k], (k == 0), "", g);
            saved[k] = g;
        end
        for (int k = 0; k < NBYTES; k++) begin
            send(saved[k], (k == 0), "", g);
            chk("R9 round trip", g, orig[k]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_hunt();
        t_frames_with_gaps();
        t_mid_sof();
        t_involution();
        idle(1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule